// File: doc/BRIEF.md
# Multidrop Scan Bridge Selection Controller

This block decides whether one bridge device on a shared, multidrop scan backplane is currently addressed. It follows the backplane TAP controller state, which arrives as a 4-bit encoded input, and keeps its own 8-bit instruction shifter in the scan path during Shift-IR. When the backplane passes through Update-IR while the block waits for an address, the shifted value is compared with the device's direct address, taken from static pins, and with a small set of fixed special codes. The block then moves to a selected or an unselected state.

A device selected through its own direct address may drive the shared TDO line. A device selected through the broadcast code or a multicast group code keeps its TDO driver off, so that many listeners never fight over the line. Multicast membership is held in a small group register. A selected device loads it with a dedicated instruction followed by a data scan. A return-to-wait instruction, or Test-Logic-Reset on the backplane, puts every bridge back into the waiting state.

Top module: `jtag_addr_sel`

## Requirements
- R1: Synchronous active-high reset puts the block in the waiting state, with `selected`, `bcast_mode` and `tdo_en` low and the group register cleared (not a member).
- R2: TAP states use the encoding TLR=F, RTI=C, SelDR=7, CapDR=6, ShiftDR=2, Exit1DR=1, PauseDR=3, Exit2DR=0, UpdDR=5, SelIR=4, CapIR=E, ShiftIR=A, Exit1IR=9, PauseIR=B, Exit2IR=8, UpdIR=D. In each ShiftIR clock the instruction shifter takes `tdi`, least significant bit first, so after 8 shifts the first bit sits in bit 0.
- R3: In the waiting state, an UpdIR with a shifted value equal to the zero-extended `dev_addr` selects the device with `bcast_mode` low. One cycle after each ShiftIR or ShiftDR clock in that state, `tdo_en` is high, and it is low otherwise.
- R4: A `dev_addr` of zero never selects the device, even when the shifted value is 0x00.
- R5: The value 0x3B selects every waiting device with `bcast_mode` high, and `tdo_en` then stays low in every state.
- R6: A value 0x3C+g (g from 0 to 3) selects a waiting device with `bcast_mode` high only when the group register has its enable bit (bit 2) set and its group field (bits 1:0) equal to g. Otherwise the device becomes unselected.
- R7: Any other value at UpdIR, including the interrogation code 0x3A, makes a waiting device unselected. It stays unselected through later UpdIR events, even ones that carry its own address, until TLR or the return-to-wait instruction.
- R8: The return-to-wait instruction 0xC3, seen at UpdIR, brings the block to the waiting state from the waiting, selected or unselected state.
- R9: The TLR state on the backplane returns the block to the waiting state on the next clock.
- R10: In the selected state, the group-select instruction 0xE1 followed by a 3-bit data scan (shifted least significant bit first, loaded at UpdDR) writes the group register.
- R11: Instructions other than 0xC3 have no effect on a device that is not selected. In particular, 0xE1 and a data scan leave the group register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backplane test clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| tap_state | input | 4 | Encoded backplane TAP controller state |
| tdi | input | 1 | Backplane serial data in |
| dev_addr | input | ADDR_W | Static direct address of this device |
| selected | output | 1 | Device is currently selected |
| bcast_mode | output | 1 | Selection was made by a broadcast or multicast code |
| tdo_en | output | 1 | Enable for the backplane TDO driver |

## Verification
On every cycle the assertions check the following: TDO is never enabled in broadcast or multicast mode, or while the device is unselected. TLR and the return-to-wait code always drop the selection, and a zero device address never causes a selection. Selection changes only at UpdIR or TLR. The bench scenarios alone show the outcome of the address comparisons. These are the direct, broadcast and group matches, the interrogation code and foreign addresses that lock a device out, the loading of the group register, and the fact that the group-select instruction is ignored while the device is unselected.

// File: rtl/jtag_sel_pkg.sv
package jtag_sel_pkg;

  localparam int IR_W = 8;

  typedef enum logic [3:0] {
    TAP_EXIT2_DR = 4'h0,
    TAP_EXIT1_DR = 4'h1,
    TAP_SHIFT_DR = 4'h2,
    TAP_PAUSE_DR = 4'h3,
    TAP_SEL_IR   = 4'h4,
    TAP_UPD_DR   = 4'h5,
    TAP_CAP_DR   = 4'h6,
    TAP_SEL_DR   = 4'h7,
    TAP_EXIT2_IR = 4'h8,
    TAP_EXIT1_IR = 4'h9,
    TAP_SHIFT_IR = 4'hA,
    TAP_PAUSE_IR = 4'hB,
    TAP_RTI      = 4'hC,
    TAP_UPD_IR   = 4'hD,
    TAP_CAP_IR   = 4'hE,
    TAP_TLR      = 4'hF
  } tap_st_e;

  typedef enum logic [1:0] {
    SEL_WAIT = 2'd0,
    SEL_ON   = 2'd1,
    SEL_OFF  = 2'd2
  } sel_st_e;

  localparam logic [IR_W-1:0] CODE_BCAST      = 8'h3B;
  localparam logic [IR_W-1:0] CODE_MCAST_BASE = 8'h3C;
  localparam logic [IR_W-1:0] OP_GOTOWAIT     = 8'hC3;
  localparam logic [IR_W-1:0] OP_GRPSEL       = 8'hE1;
  localparam logic [IR_W-1:0] OP_BYPASS       = 8'hFF;

endpackage

// File: rtl/scan_shreg.sv
module scan_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         sin,
  output logic [W-1:0] q
);
  // The serial bit enters at the top, so the first bit shifted in ends at bit 0
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (shift_en) q <= {sin, q[W-1:1]};
  end
endmodule

// File: rtl/addr_match.sv
module addr_match
  import jtag_sel_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int GRP_W  = 2
) (
  input  logic [IR_W-1:0]   code,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              grp_en,
  input  logic [GRP_W-1:0]  grp_id,
  output logic              hit_direct,
  output logic              hit_group
);
  localparam int PAD_W = IR_W - ADDR_W;

  logic [IR_W-1:0] addr_ext;
  logic            is_bcast;
  logic            is_mcast;

  generate
    if (PAD_W > 0) begin : g_pad
      assign addr_ext = {{PAD_W{1'b0}}, dev_addr};
    end else begin : g_nopad
      assign addr_ext = dev_addr[IR_W-1:0];
    end
  endgenerate

  always_comb begin
    hit_direct = (dev_addr != '0) && (code == addr_ext);
    is_bcast   = (code == CODE_BCAST);
    is_mcast   = grp_en
                 && (code[IR_W-1:GRP_W] == CODE_MCAST_BASE[IR_W-1:GRP_W])
                 && (code[GRP_W-1:0] == grp_id);
    hit_group  = is_bcast || is_mcast;
  end
endmodule

// File: rtl/jtag_addr_sel.sv
module jtag_addr_sel
  import jtag_sel_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int GRP_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        tap_state,
  input  logic              tdi,
  input  logic [ADDR_W-1:0] dev_addr,
  output logic              selected,
  output logic              bcast_mode,
  output logic              tdo_en
);
  localparam int GREG_W = GRP_W + 1;  // enable bit on top of the group id

  tap_st_e          tap;
  sel_st_e          st_q, st_d;
  logic             bc_q, bc_d;
  logic [IR_W-1:0]  ir_q;
  logic [IR_W-1:0]  instr_q;
  logic [GREG_W-1:0] dr_q;
  logic [GREG_W-1:0] grp_q;
  logic             hit_direct, hit_group;
  logic             shifting;

  assign tap      = tap_st_e'(tap_state);
  assign shifting = (tap == TAP_SHIFT_IR) || (tap == TAP_SHIFT_DR);

  scan_shreg #(.W(IR_W)) u_ir (
    .clk(clk), .rst(rst), .shift_en(tap == TAP_SHIFT_IR), .sin(tdi), .q(ir_q)
  );

  scan_shreg #(.W(GREG_W)) u_dr (
    .clk(clk), .rst(rst), .shift_en(tap == TAP_SHIFT_DR), .sin(tdi), .q(dr_q)
  );

  addr_match #(.ADDR_W(ADDR_W), .GRP_W(GRP_W)) u_match (
    .code(ir_q), .dev_addr(dev_addr),
    .grp_en(grp_q[GREG_W-1]), .grp_id(grp_q[GRP_W-1:0]),
    .hit_direct(hit_direct), .hit_group(hit_group)
  );

  always_comb begin
    st_d = st_q;
    bc_d = bc_q;
    if (tap == TAP_TLR) begin
      st_d = SEL_WAIT;
      bc_d = 1'b0;
    end else if (tap == TAP_UPD_IR) begin
      if (ir_q == OP_GOTOWAIT) begin
        st_d = SEL_WAIT;
        bc_d = 1'b0;
      end else if (st_q == SEL_WAIT) begin
        if (hit_direct) begin
          st_d = SEL_ON;
          bc_d = 1'b0;
        end else if (hit_group) begin
          st_d = SEL_ON;
          bc_d = 1'b1;
        end else begin
          st_d = SEL_OFF;
          bc_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SEL_WAIT;
      bc_q    <= 1'b0;
      instr_q <= OP_BYPASS;
      grp_q   <= '0;
      tdo_en  <= 1'b0;
    end else begin
      st_q   <= st_d;
      bc_q   <= bc_d;
      tdo_en <= (st_d == SEL_ON) && !bc_d && shifting;
      if (tap == TAP_TLR) begin
        instr_q <= OP_BYPASS;
      end else if (tap == TAP_UPD_IR) begin
        // only a device already selected takes the value as an instruction
        instr_q <= (st_q == SEL_ON) ? ir_q : OP_BYPASS;
      end
      if (tap == TAP_UPD_DR && st_q == SEL_ON && instr_q == OP_GRPSEL)
        grp_q <= dr_q;
    end
  end

  assign selected   = (st_q == SEL_ON);
  assign bcast_mode = bc_q;
endmodule

// File: rtl/jtag_addr_sel_chk.sv
module jtag_addr_sel_chk
  import jtag_sel_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        tap_state,
  input logic [ADDR_W-1:0] dev_addr,
  input logic [IR_W-1:0]   ir_q,
  input logic              selected,
  input logic              bcast_mode,
  input logic              tdo_en
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!selected && !bcast_mode && !tdo_en));

  assert_tdo_needs_select_R3: assert property (@(posedge clk) disable iff (rst)
    tdo_en |-> selected);

  assert_tdo_after_shift_R3: assert property (@(posedge clk) disable iff (rst)
    tdo_en |-> ($past(tap_state) == TAP_SHIFT_IR || $past(tap_state) == TAP_SHIFT_DR));

  assert_zero_addr_never_R4: assert property (@(posedge clk) disable iff (rst)
    (tap_state == TAP_UPD_IR && dev_addr == '0 && ir_q == '0 && !selected) |=> !selected);

  assert_group_no_drive_R5: assert property (@(posedge clk) disable iff (rst)
    bcast_mode |-> !tdo_en);

  assert_sel_changes_only_update_R7: assert property (@(posedge clk) disable iff (rst)
    !(tap_state == TAP_UPD_IR || tap_state == TAP_TLR) |=> $stable(selected));

  assert_gotowait_R8: assert property (@(posedge clk) disable iff (rst)
    (tap_state == TAP_UPD_IR && ir_q == OP_GOTOWAIT) |=> (!selected && !bcast_mode));

  assert_tlr_wait_R9: assert property (@(posedge clk) disable iff (rst)
    (tap_state == TAP_TLR) |=> (!selected && !bcast_mode && !tdo_en));
endmodule

bind jtag_addr_sel jtag_addr_sel_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .tap_state(tap_state), .dev_addr(dev_addr),
  .ir_q(ir_q), .selected(selected), .bcast_mode(bcast_mode), .tdo_en(tdo_en)
);

// File: tb/jtag_addr_sel_tb_top.sv
`timescale 1ns/1ps
module jtag_addr_sel_tb_top;
  import jtag_sel_pkg::*;

  localparam int ADDR_W = 7;
  localparam logic [ADDR_W-1:0] MY_ADDR = 7'h15;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [3:0]        tap_state = TAP_TLR;
  logic              tdi = 1'b0;
  logic [ADDR_W-1:0] dev_addr = MY_ADDR;
  logic              selected, bcast_mode, tdo_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  jtag_addr_sel #(.ADDR_W(ADDR_W), .GRP_W(2)) dut_i (
    .clk(clk), .rst(rst), .tap_state(tap_state), .tdi(tdi),
    .dev_addr(dev_addr), .selected(selected), .bcast_mode(bcast_mode), .tdo_en(tdo_en)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic step(input tap_st_e s, input logic b);
    @(negedge clk);
    tap_state = s;
    tdi = b;
  endtask

  task automatic go_tlr();
    step(TAP_TLR, 1'b0);
    step(TAP_RTI, 1'b0);
  endtask

  task automatic shift_ir(input logic [7:0] v);
    step(TAP_SEL_DR, 1'b0);
    step(TAP_SEL_IR, 1'b0);
    step(TAP_CAP_IR, 1'b0);
    for (int i = 0; i < 8; i++) step(TAP_SHIFT_IR, v[i]);
    step(TAP_EXIT1_IR, 1'b0);
    step(TAP_UPD_IR, 1'b0);
    step(TAP_RTI, 1'b0);
  endtask

  task automatic shift_dr3(input logic [2:0] v);
    step(TAP_SEL_DR, 1'b0);
    step(TAP_CAP_DR, 1'b0);
    for (int i = 0; i < 3; i++) step(TAP_SHIFT_DR, v[i]);
    step(TAP_EXIT1_DR, 1'b0);
    step(TAP_UPD_DR, 1'b0);
    step(TAP_RTI, 1'b0);
  endtask

  // passes through Shift-DR and samples the TDO enable inside and after it
  task automatic probe_tdo(input logic exp_in, input string req);
    step(TAP_SEL_DR, 1'b0);
    step(TAP_CAP_DR, 1'b0);
    step(TAP_SHIFT_DR, 1'b0);
    step(TAP_SHIFT_DR, 1'b0);
    chk(tdo_en, exp_in, {req, " tdo_en during shift"});
    step(TAP_EXIT1_DR, 1'b0);
    step(TAP_UPD_DR, 1'b0);
    step(TAP_RTI, 1'b0);
    chk(tdo_en, 1'b0, {req, " tdo_en after shift"});
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    chk(selected, 1'b0, "R1 selected in reset");
    chk(bcast_mode, 1'b0, "R1 bcast_mode in reset");
    chk(tdo_en, 1'b0, "R1 tdo_en in reset");
    @(negedge clk);
    rst = 1'b0;
    tap_state = TAP_RTI;
  endtask

  task automatic t_direct();
    shift_ir({1'b0, MY_ADDR});
    chk(selected, 1'b1, "R2 R3 direct address selects");
    chk(bcast_mode, 1'b0, "R3 direct is not broadcast");
    probe_tdo(1'b1, "R3");
    go_tlr();
    chk(selected, 1'b0, "R9 TLR deselects");
  endtask

  task automatic t_foreign();
    shift_ir(8'h22);
    chk(selected, 1'b0, "R7 foreign address");
    shift_ir({1'b0, MY_ADDR});
    chk(selected, 1'b0, "R7 own address ignored while unselected");
    shift_ir(OP_GOTOWAIT);
    chk(selected, 1'b0, "R8 return to wait from unselected");
    shift_ir({1'b0, MY_ADDR});
    chk(selected, 1'b1, "R8 addressable again after return to wait");
    go_tlr();
  endtask

  task automatic t_interrogate();
    shift_ir(8'h3A);
    chk(selected, 1'b0, "R7 interrogation code does not select");
    go_tlr();
  endtask

  task automatic t_broadcast();
    shift_ir(CODE_BCAST);
    chk(selected, 1'b1, "R5 broadcast selects");
    chk(bcast_mode, 1'b1, "R5 broadcast flag");
    probe_tdo(1'b0, "R5");
    go_tlr();
    chk(bcast_mode, 1'b0, "R9 TLR clears broadcast flag");
  endtask

  task automatic t_mcast_no_member();
    shift_ir(8'h3C);
    chk(selected, 1'b0, "R6 R1 multicast without membership");
    go_tlr();
  endtask

  task automatic t_group_load();
    shift_ir({1'b0, MY_ADDR});
    shift_ir(OP_GRPSEL);
    chk(selected, 1'b1, "R10 stays selected after group-select");
    shift_dr3(3'b110);  // enable, group 2
    shift_ir(OP_GOTOWAIT);
    chk(selected, 1'b0, "R8 return to wait from selected");
    shift_ir(8'h3E);
    chk(selected, 1'b1, "R10 R6 programmed group selects");
    chk(bcast_mode, 1'b1, "R6 multicast flag");
    probe_tdo(1'b0, "R6");
    shift_ir(OP_GOTOWAIT);
    shift_ir(8'h3D);
    chk(selected, 1'b0, "R6 other group does not select");
    go_tlr();
  endtask

  task automatic t_unsel_ignored();
    shift_ir(8'h40);
    shift_ir(OP_GRPSEL);
    shift_dr3(3'b101);  // would move membership to group 1
    go_tlr();
    shift_ir(8'h3D);
    chk(selected, 1'b0, "R11 group register untouched while unselected");
    go_tlr();
    shift_ir(8'h3E);
    chk(selected, 1'b1, "R11 earlier group still held");
    go_tlr();
  endtask

  task automatic t_zero_addr();
    dev_addr = '0;
    shift_ir(8'h00);
    chk(selected, 1'b0, "R4 zero address never selects");
    go_tlr();
    dev_addr = MY_ADDR;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_direct();
    t_foreign();
    t_interrogate();
    t_broadcast();
    t_mcast_no_member();
    t_group_load();
    t_unsel_ignored();
    t_zero_addr();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end
endmodule